// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt-control slice of a processor core. It owns the status word, made of a global interrupt-enable bit and a current priority level. It also owns a saved copy of that word, a per-source enable mask, and a view of the qualified requests, called the pending set. Each cycle it checks the request lines from its sources. It takes an interrupt when the global enable is on and the best pending source has a higher priority than the level now running.

When an interrupt is taken, the block does several things in the same clock edge. It copies the status into the saved register and clears the global enable. It raises the current level to the chosen source's level. It emits the source's index and its handler address, which lies at a fixed table base plus four bytes per index. It pulses an acknowledge on that source's line, so the source can drop its request. A return pulse from the core copies the saved word back into the status.

Software reaches the registers through a plain control-move port. The port has one write strobe, a two-bit selector, write data and combinational read data. No part of this block carries a data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal that holds its meaning in each cycle.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, the status word, the saved word and the enable mask are all zero, and take_o, dev_ack_o and vec_addr_o are zero.
- R2: The pending set equals dev_req_i AND the enable mask, bit for bit. It is read with selector 3 in bits [NUM_DEV-1:0].
- R3: While the status enable bit (bit 0 of the status word) is 0, no interrupt is taken, whatever the requests.
- R4: An interrupt is taken in the cycle after a qualifying request is seen. take_o is high for exactly one cycle. dev_ack_o is high for that same cycle only, on the chosen source's bit only.
- R5: When several sources are pending, the lowest-numbered one is chosen. Its index appears on irq_id_o.
- R6: vec_addr_o equals VEC_BASE plus 4 times the chosen index. It is updated when an interrupt is taken.
- R7: On a take, the saved word receives the previous status and the enable bit is cleared. The level field (bits [LVL_W:1]) becomes NUM_DEV minus the chosen index.
- R8: A request is taken only when its level (NUM_DEV minus its index) is strictly greater than the current level. Otherwise it stays pending.
- R9: A one-cycle rti_i pulse copies the saved word into the status word.
- R10: The move port works by selector. Selector 0 reads and writes the status word, 1 reads and writes the saved word, and 2 reads and writes the enable mask. Selector 3 is read-only, and writes to it change nothing.
- R11: When rti_i is high in the same cycle as a qualifying request, the return wins and no interrupt is taken at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req_i | input | NUM_DEV | Request level from each source |
| dev_ack_o | output | NUM_DEV | One-cycle acknowledge to the chosen source |
| take_o | output | 1 | One-cycle pulse when an interrupt is taken |
| irq_id_o | output | IDX_W | Index of the last source taken |
| vec_addr_o | output | ADDR_W | Handler address of the last source taken |
| rti_i | input | 1 | Return-from-interrupt pulse |
| mv_wr_i | input | 1 | Control-move write strobe |
| mv_sel_i | input | 2 | Register selector (0 status, 1 saved, 2 enable, 3 pending) |
| mv_wdata_i | input | DATA_W | Control-move write data |
| mv_rdata_o | output | DATA_W | Control-move read data, combinational |

## Verification
The bench tries all 256 request patterns against three enable masks and three current levels: 0, a middle level, and the top level. Together these separate the masking by enable from the choice of the lowest index and from the strict level comparison. The same 256 patterns are repeated with the global enable off, to show that pending requests alone never trigger a take. Directed cases cover a write to the read-only pending selector and a return pulse that coincides with a live request. These show that the restore takes precedence and that the pending view is unaffected.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_SAVED  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_PEND   = 2'd3
  } pvi_sel_e;

  localparam int unsigned VEC_STRIDE_LG = 2;
endpackage

// File: rtl/pvi_pick.sv
module pvi_pick #(
  parameter int unsigned NUM_DEV = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_DEV)
) (
  input  logic [NUM_DEV-1:0] pend_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    idx_o = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/pvi_regs.sv
module pvi_regs #(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned LVL_W  = $clog2(NUM_DEV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [LVL_W-1:0]   take_lvl_i,
  input  logic               rti_i,
  input  logic               wr_i,
  input  logic [1:0]         sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ie_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic               sv_ie_o,
  output logic [LVL_W-1:0]   sv_lvl_o,
  output logic [NUM_DEV-1:0] en_o
);
  import pvi_pkg::*;

  logic wr_stat, wr_save, wr_en;
  assign wr_stat = wr_i && (pvi_sel_e'(sel_i) == SEL_STATUS);
  assign wr_save = wr_i && (pvi_sel_e'(sel_i) == SEL_SAVED);
  assign wr_en   = wr_i && (pvi_sel_e'(sel_i) == SEL_ENABLE);

  // Live status: return beats take, take beats software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_o  <= 1'b0;
      lvl_o <= '0;
    end else if (rti_i) begin
      ie_o  <= sv_ie_o;
      lvl_o <= sv_lvl_o;
    end else if (take_i) begin
      ie_o  <= 1'b0;
      lvl_o <= take_lvl_i;
    end else if (wr_stat) begin
      ie_o  <= wdata_i[0];
      lvl_o <= wdata_i[LVL_W:1];
    end
  end

  // Saved status: hardware save on take beats software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_ie_o  <= 1'b0;
      sv_lvl_o <= '0;
    end else if (take_i) begin
      sv_ie_o  <= ie_o;
      sv_lvl_o <= lvl_o;
    end else if (wr_save) begin
      sv_ie_o  <= wdata_i[0];
      sv_lvl_o <= wdata_i[LVL_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_o <= '0;
    else if (wr_en) en_o <= wdata_i[NUM_DEV-1:0];
  end

  p_save_on_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i) |-> (sv_ie_o == $past(ie_o)) && (sv_lvl_o == $past(lvl_o)));

  p_ie_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i) |-> !ie_o);

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rti_i) |-> (ie_o == $past(sv_ie_o)) && (lvl_o == $past(sv_lvl_o)));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int unsigned NUM_DEV  = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0200,
  localparam int unsigned IDX_W   = $clog2(NUM_DEV),
  localparam int unsigned LVL_W   = $clog2(NUM_DEV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] dev_req_i,
  output logic [NUM_DEV-1:0] dev_ack_o,
  output logic               take_o,
  output logic [IDX_W-1:0]   irq_id_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  input  logic               rti_i,
  input  logic               mv_wr_i,
  input  logic [1:0]         mv_sel_i,
  input  logic [DATA_W-1:0]  mv_wdata_i,
  output logic [DATA_W-1:0]  mv_rdata_o
);
  import pvi_pkg::*;

  logic               ie, sv_ie;
  logic [LVL_W-1:0]   lvl, sv_lvl;
  logic [NUM_DEV-1:0] en, pend;
  logic               any;
  logic [IDX_W-1:0]   idx;
  logic [LVL_W-1:0]   cand_lvl;
  logic               fire;
  logic [NUM_DEV-1:0] ack_d;
  logic [ADDR_W-1:0]  vec_d;

  assign pend = dev_req_i & en;

  pvi_pick #(.NUM_DEV(NUM_DEV)) pick_i (
    .pend_i (pend),
    .any_o  (any),
    .idx_o  (idx)
  );

  // Source i sits at level NUM_DEV - i, so index 0 is the most urgent.
  assign cand_lvl = LVL_W'(NUM_DEV) - LVL_W'(idx);
  assign fire     = ie && any && (cand_lvl > lvl) && !rti_i;
  assign vec_d    = ADDR_W'(VEC_BASE) + (ADDR_W'(idx) << VEC_STRIDE_LG);

  generate
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_ack
      assign ack_d[g] = fire && (idx == IDX_W'(g));
    end
  endgenerate

  pvi_regs #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (fire),
    .take_lvl_i (cand_lvl),
    .rti_i      (rti_i),
    .wr_i       (mv_wr_i),
    .sel_i      (mv_sel_i),
    .wdata_i    (mv_wdata_i),
    .ie_o       (ie),
    .lvl_o      (lvl),
    .sv_ie_o    (sv_ie),
    .sv_lvl_o   (sv_lvl),
    .en_o       (en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      dev_ack_o  <= '0;
      irq_id_o   <= '0;
      vec_addr_o <= '0;
    end else begin
      take_o    <= fire;
      dev_ack_o <= ack_d;
      if (fire) begin
        irq_id_o   <= idx;
        vec_addr_o <= vec_d;
      end
    end
  end

  always_comb begin
    mv_rdata_o = '0;
    unique case (pvi_sel_e'(mv_sel_i))
      SEL_STATUS: mv_rdata_o[LVL_W:0]     = {lvl, ie};
      SEL_SAVED:  mv_rdata_o[LVL_W:0]     = {sv_lvl, sv_ie};
      SEL_ENABLE: mv_rdata_o[NUM_DEV-1:0] = en;
      SEL_PEND:   mv_rdata_o[NUM_DEV-1:0] = pend;
      default:    mv_rdata_o = '0;
    endcase
  end

  p_take_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack_o) && (take_o == (dev_ack_o != '0)));

  p_ie_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(ie));

  p_level_rises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (lvl > $past(lvl)));

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(pend[idx]) || $past(pend[irq_id_o]));

  p_rti_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rti_i) |-> !take_o);
endmodule

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
  localparam int NDEV = 8;
  localparam logic [31:0] BASE = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [7:0]  ack;
  logic        take;
  logic [2:0]  id;
  logic [31:0] vec;
  logic        rti = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .dev_req_i(req), .dev_ack_o(ack),
    .take_o(take), .irq_id_o(id), .vec_addr_o(vec), .rti_i(rti),
    .mv_wr_i(wr), .mv_sel_i(sel), .mv_wdata_i(wdata), .mv_rdata_o(rdata)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] v);
    sel = s;
    #1;
    v = rdata;
  endtask

  task automatic mv(logic [1:0] s, logic [31:0] d);
    wr = 1'b1; sel = s; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic run_case(logic [7:0] en, int lv, logic ie, logic [7:0] r);
    logic [31:0] v;
    logic [7:0]  p;
    int          ix;
    logic        exp_take;
    p  = r & en;
    ix = 0;
    for (int i = NDEV - 1; i >= 0; i--) if (p[i]) ix = i;
    exp_take = ie && (p != 0) && ((NDEV - ix) > lv);
    req = '0;
    mv(2'd0, 32'(lv << 1));
    mv(2'd2, 32'(en));
    req = r;
    mv(2'd0, 32'((lv << 1) | int'(ie)));
    rd(2'd3, v);
    chk("R2 pending", v, 32'(p));
    step();
    chk(ie ? "R4/R8 take" : "R3 no take", 32'(take), 32'(exp_take));
    chk("R4 ack", 32'(ack), exp_take ? 32'(1 << ix) : 32'h0);
    rd(2'd0, v);
    chk("R7 status", v, exp_take ? 32'((NDEV - ix) << 1) : 32'((lv << 1) | int'(ie)));
    if (exp_take) begin
      chk("R5 id", 32'(id), 32'(ix));
      chk("R6 vector", vec, BASE + 32'(ix * 4));
      rd(2'd1, v);
      chk("R7 saved", v, 32'((lv << 1) | int'(ie)));
    end
    step();
    chk("R4 pulse end", 32'({take, ack}), 32'h0);
    if (exp_take) begin
      rti = 1'b1;
      step();
      rti = 1'b0;
      rd(2'd0, v);
      chk("R9 restore", v, 32'((lv << 1) | int'(ie)));
    end
    req = '0;
    mv(2'd0, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0]  masks [3];
    int          lvls  [3];
    masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h3C;
    lvls[0] = 0; lvls[1] = 3; lvls[2] = 8;
    @(negedge clk);
    @(negedge clk);
    rd(2'd0, v); chk("R1 status", v, 32'h0);
    rd(2'd1, v); chk("R1 saved", v, 32'h0);
    rd(2'd2, v); chk("R1 enable", v, 32'h0);
    chk("R1 outputs", 32'({take, ack}) | vec, 32'h0);
    rst_n = 1'b1;
    step();
    for (int m = 0; m < 3; m++)
      for (int l = 0; l < 3; l++)
        for (int r = 0; r < 256; r++)
          run_case(masks[m], lvls[l], 1'b1, 8'(r));
    for (int r = 0; r < 256; r++) run_case(8'hFF, 0, 1'b0, 8'(r));

    // R10: a write to the pending selector changes nothing.
    mv(2'd2, 32'h0F);
    req = 8'h33;
    mv(2'd3, 32'hFF);
    rd(2'd3, v); chk("R10 pending read-only", v, 32'h03);
    rd(2'd2, v); chk("R10 enable kept", v, 32'h0F);
    mv(2'd1, 32'h0000_000B);
    rd(2'd1, v); chk("R10 saved write", v, 32'h0B);

    // R11: a return pulse at the same edge as a live request wins.
    req = '0;
    mv(2'd1, 32'h0);
    mv(2'd0, 32'h1);
    req = 8'h01; rti = 1'b1;
    step();
    rti = 1'b0;
    chk("R11 no take", 32'(take), 32'h0);
    rd(2'd0, v); chk("R11 status restored", v, 32'h0);
    req = '0;
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule